// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller with Priority Chain

This block gathers eight interrupt conditions from the rest of a peripheral into a status register. It combines them with an eight-bit enable mask. When at least one enabled condition is pending, it pulls an active-low request line low. When the processor runs an interrupt-acknowledge cycle, the block answers by presenting a programmable eight-bit vector, flagged by an output-enable. It also pulses a one-cycle completion strobe.

Several such blocks can share one request line in priority order. A configuration bit turns on chain operation, which uses a chain-enable input and a chain-enable output. In that mode a device further up the chain can silence this one by pulling the chain input low. This device then passes the block further down the chain whenever it has something pending itself. With chain operation off, the chain signal simply passes through.

A small register port writes and reads the mask, vector and configuration registers, and reads the status register.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the mask reads 0x00, the vector reads 0x0F and the configuration reads 0x00. The request output is high, and the vector enable and the completion strobe are low.
- R2: Register select 0 reads the status register. It shows the raw condition inputs sampled at the previous clock edge, whatever the mask holds.
- R3: With chain operation off, the request output is low exactly when the status register ANDed with the mask is non-zero.
- R4: A write with select 1 loads the mask, select 2 loads the vector, and select 3 loads the configuration from data bit 0 (bit 0 = chain operation on). Reads with the same select return the stored value, with the configuration zero-extended. A write with select 0 changes no register.
- R5: The acknowledge input is active low. The first clock edge at which it is low (after being high) is the acknowledge start. If the request is being granted at that edge, then in the following cycle the vector enable is high, the vector output carries the vector register as it stood at that edge, and the completion strobe is high for exactly that one cycle.
- R6: Once raised, the vector enable stays high, and the vector output stays unchanged, until the first clock edge at which the acknowledge input is sampled high. It is low from the next cycle on. A held acknowledge yields only one completion strobe.
- R7: An acknowledge start with no pending enabled condition produces neither the vector enable nor the completion strobe.
- R8: With chain operation off, the chain output equals the chain input, and the chain input does not affect the request or acknowledge handling.
- R9: With chain operation on and the chain input low, the request output is high, the chain output is low, and an acknowledge is ignored.
- R10: With chain operation on and the chain input high, the chain output is low exactly when an enabled condition is pending, and the request behaves as in R3.
- R11: The vector output is all zeros whenever the vector enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 8 | Interrupt condition inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 8 | Read data of selected register |
| ack_n_i | input | 1 | Interrupt acknowledge, active low |
| chain_in_i | input | 1 | Chain enable from higher-priority device |
| chain_out_o | output | 1 | Chain enable to lower-priority device |
| irq_n_o | output | 1 | Interrupt request, active low |
| vec_o | output | 8 | Vector output |
| vec_oe_o | output | 1 | Vector output valid |
| ack_done_o | output | 1 | One-cycle acknowledge completion strobe |

## Verification
A corrupted mask or status register shows up on the request line in the same cycle it is corrupted, and the chain output shows it too when chain operation is on. A wrong vector register appears on the vector output in the cycle after the next acknowledge start. A broken acknowledge edge detector or hold flop shows within one or two cycles as a doubled strobe or a vector enable that outlives the acknowledge. The bench compares every output against its own model on every cycle, so a divergence is reported in the first cycle it becomes visible.

// File: rtl/irq_vec_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes register selects are two bits wide.
package irq_vec_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_CONFIG = 2'd3
    } reg_sel_e;

    localparam int unsigned DEF_SRC   = 8;
    localparam int unsigned DEF_DATA  = 8;
    localparam logic [7:0]  DEF_VRST  = 8'h0F;
endpackage

// File: rtl/irq_regs.sv
// Register file: status capture, mask, vector and configuration.
// Assumes NUM_SRC <= DATA_W; the status is zero-extended on read.
module irq_regs
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_SRC,
    parameter int unsigned DATA_W  = DEF_DATA,
    parameter logic [DATA_W-1:0] VEC_RST = DATA_W'(DEF_VRST)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cond_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [1:0]         rd_sel_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [DATA_W-1:0]  vector_o,
    output logic               chain_en_o
);
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  vector_q;
    logic               chain_q;
    logic [DATA_W-1:0]  status_ext;
    logic [DATA_W-1:0]  mask_ext;
    logic [DATA_W-1:0]  cfg_ext;
    reg_sel_e           wsel;
    reg_sel_e           rsel;

    assign wsel = reg_sel_e'(wr_sel_i);
    assign rsel = reg_sel_e'(rd_sel_i);

    // Capture the raw condition inputs every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= cond_i;
    end

    // Software-writable registers; select 0 is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            vector_q <= VEC_RST;
            chain_q  <= 1'b0;
        end else if (wr_en_i) begin
            case (wsel)
                SEL_MASK:   mask_q   <= wr_data_i[NUM_SRC-1:0];
                SEL_VECTOR: vector_q <= wr_data_i;
                SEL_CONFIG: chain_q  <= wr_data_i[0];
                default:    ;
            endcase
        end
    end

    // Zero-extend narrow registers to the data width.
    always_comb begin
        status_ext = '0;
        mask_ext   = '0;
        cfg_ext    = '0;
        status_ext[NUM_SRC-1:0] = status_q;
        mask_ext[NUM_SRC-1:0]   = mask_q;
        cfg_ext[0]              = chain_q;
    end

    // Read multiplexer.
    always_comb begin
        case (rsel)
            SEL_STATUS: rd_data_o = status_ext;
            SEL_MASK:   rd_data_o = mask_ext;
            SEL_VECTOR: rd_data_o = vector_q;
            default:    rd_data_o = cfg_ext;
        endcase
    end

    assign status_o   = status_q;
    assign mask_o     = mask_q;
    assign vector_o   = vector_q;
    assign chain_en_o = chain_q;
endmodule

// File: rtl/irq_req.sv
// Request generation and chain propagation.
// Purely combinational; assumes registered status and mask inputs.
module irq_req #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               chain_en_i,
    input  logic               chain_in_i,
    output logic               pending_o,
    output logic               grant_o,
    output logic               irq_n_o,
    output logic               chain_out_o
);
    logic [NUM_SRC-1:0] hit;
    logic               gate;

    // Per-source enabled hit.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
        assign hit[i] = status_i[i] & mask_i[i];
    end

    // Gate from chain input only when chain operation is on.
    always_comb begin
        pending_o   = |hit;
        gate        = chain_en_i ? chain_in_i : 1'b1;
        grant_o     = pending_o & gate;
        irq_n_o     = ~grant_o;
        chain_out_o = chain_en_i ? (chain_in_i & ~pending_o) : chain_in_i;
    end
endmodule

// File: rtl/irq_ack.sv
// Acknowledge handling: edge detect, vector latch and output enable.
// Assumes ack_n_i is synchronous to clk.
module irq_ack #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_n_i,
    input  logic              grant_i,
    input  logic [DATA_W-1:0] vector_i,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_oe_o,
    output logic              ack_done_o
);
    logic              ack_q;
    logic              start;
    logic              take;
    logic              oe_q;
    logic              done_q;
    logic [DATA_W-1:0] vec_q;

    assign start = ~ack_n_i & ack_q;
    assign take  = start & grant_i;

    // Remember the previous acknowledge level.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b1;
        else        ack_q <= ack_n_i;
    end

    // Output enable and strobe sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            oe_q   <= take | (oe_q & ~ack_n_i);
            done_q <= take;
        end
    end

    // Latch the vector at acknowledge start.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_q <= '0;
        else if (take) vec_q <= vector_i;
    end

    assign vec_o      = oe_q ? vec_q : '0;
    assign vec_oe_o   = oe_q;
    assign ack_done_o = done_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
// Top: vectored maskable interrupt controller with optional priority chain.
// Assumes all inputs synchronous to clk; condition sources are external.
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_SRC,
    parameter int unsigned DATA_W  = DEF_DATA,
    parameter logic [DATA_W-1:0] VEC_RST = DATA_W'(DEF_VRST)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cond_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [1:0]         rd_sel_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic               ack_n_i,
    input  logic               chain_in_i,
    output logic               chain_out_o,
    output logic               irq_n_o,
    output logic [DATA_W-1:0]  vec_o,
    output logic               vec_oe_o,
    output logic               ack_done_o
);
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [DATA_W-1:0]  vector;
    logic               chain_en;
    logic               pending;
    logic               grant;

    irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .VEC_RST(VEC_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (cond_i),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .rd_sel_i   (rd_sel_i),
        .rd_data_o  (rd_data_o),
        .status_o   (status),
        .mask_o     (mask),
        .vector_o   (vector),
        .chain_en_o (chain_en)
    );

    irq_req #(.NUM_SRC(NUM_SRC)) u_req (
        .status_i    (status),
        .mask_i      (mask),
        .chain_en_i  (chain_en),
        .chain_in_i  (chain_in_i),
        .pending_o   (pending),
        .grant_o     (grant),
        .irq_n_o     (irq_n_o),
        .chain_out_o (chain_out_o)
    );

    irq_ack #(.DATA_W(DATA_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_n_i    (ack_n_i),
        .grant_i    (grant),
        .vector_i   (vector),
        .vec_o      (vec_o),
        .vec_oe_o   (vec_oe_o),
        .ack_done_o (ack_done_o)
    );
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
// Assertion checker for irq_vec_ctrl, attached by bind below.
// Assumes reset is asserted from time zero.
module irq_vec_ctrl_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_n_i,
    input logic              chain_in_i,
    input logic              chain_out_o,
    input logic              irq_n_o,
    input logic [DATA_W-1:0] vec_o,
    input logic              vec_oe_o,
    input logic              ack_done_o,
    input logic              chain_en,
    input logic              grant
);
    // R11
    vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe_o |-> (vec_o == '0));

    // R5
    done_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done_o |-> vec_oe_o);

    // R5
    done_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done_o |-> ($past(grant) && !$past(ack_n_i)));

    // R6
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done_o |=> !ack_done_o);

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe_o && ack_n_i) |=> !vec_oe_o);

    // R6
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe_o && !ack_done_o) |-> $stable(vec_o));

    // R9
    chain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && !chain_in_i) |-> (irq_n_o && !chain_out_o));

    // R8
    chain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |-> (chain_out_o == chain_in_i));

    // R10
    chain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_en |-> !(chain_out_o && !irq_n_o));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_n_i     (ack_n_i),
    .chain_in_i  (chain_in_i),
    .chain_out_o (chain_out_o),
    .irq_n_o     (irq_n_o),
    .vec_o       (vec_o),
    .vec_oe_o    (vec_oe_o),
    .ack_done_o  (ack_done_o),
    .chain_en    (chain_en),
    .grant       (grant)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
    localparam real HALF = 4.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cond_i = '0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_sel_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [1:0] rd_sel_i = '0;
    logic [7:0] rd_data_o;
    logic       ack_n_i = 1'b1;
    logic       chain_in_i = 1'b1;
    logic       chain_out_o;
    logic       irq_n_o;
    logic [7:0] vec_o;
    logic       vec_oe_o;
    logic       ack_done_o;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [7:0] st_m, mk_m, vc_m, lat_m;
    logic       cf_m, ackq_m, oe_m, done_m;

    always #(HALF) clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .ack_n_i(ack_n_i), .chain_in_i(chain_in_i),
        .chain_out_o(chain_out_o), .irq_n_o(irq_n_o), .vec_o(vec_o),
        .vec_oe_o(vec_oe_o), .ack_done_o(ack_done_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic f_pend();
        return |(st_m & mk_m);
    endfunction

    function automatic logic f_irq_n();
        return !(f_pend() && (cf_m ? chain_in_i : 1'b1));
    endfunction

    function automatic logic f_chain_out();
        return cf_m ? (chain_in_i && !f_pend()) : chain_in_i;
    endfunction

    function automatic logic [7:0] f_rd(input logic [1:0] s);
        case (s)
            2'd0: return st_m;
            2'd1: return mk_m;
            2'd2: return vc_m;
            default: return {7'd0, cf_m};
        endcase
    endfunction

    task automatic model_reset();
        st_m = '0; mk_m = '0; vc_m = 8'h0F; lat_m = '0;
        cf_m = 1'b0; ackq_m = 1'b1; oe_m = 1'b0; done_m = 1'b0;
    endtask

    // Advance the model with the inputs present at this edge.
    task automatic model_step();
        logic grant, start;
        grant  = f_pend() && (cf_m ? chain_in_i : 1'b1);
        start  = !ack_n_i && ackq_m;
        done_m = start && grant;
        if (start && grant) lat_m = vc_m;
        oe_m   = (start && grant) || (oe_m && !ack_n_i);
        ackq_m = ack_n_i;
        st_m   = cond_i;
        if (wr_en_i) begin
            case (wr_sel_i)
                2'd1: mk_m = wr_data_i;
                2'd2: vc_m = wr_data_i;
                2'd3: cf_m = wr_data_i[0];
                default: ;
            endcase
        end
    endtask

    task automatic check_all();
        string t;
        t = !cf_m ? "R3" : (!chain_in_i ? "R9" : "R10");
        chk(t, "irq_n", {7'd0, irq_n_o}, {7'd0, f_irq_n()});
        t = !cf_m ? "R8" : (!chain_in_i ? "R9" : "R10");
        chk(t, "chain_out", {7'd0, chain_out_o}, {7'd0, f_chain_out()});
        t = (rd_sel_i == 2'd0) ? "R2" : "R4";
        chk(t, "rd_data", rd_data_o, f_rd(rd_sel_i));
        t = done_m ? "R5" : "R7";
        chk(t, "ack_done", {7'd0, ack_done_o}, {7'd0, done_m});
        chk("R6", "vec_oe", {7'd0, vec_oe_o}, {7'd0, oe_m});
        t = oe_m ? "R5" : "R11";
        chk(t, "vec", vec_o, oe_m ? lat_m : 8'h00);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        check_all();
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
        cycle();
        wr_en_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        seed = $urandom(32'h1F2E3D4C);
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset values
        for (int s = 0; s < 4; s++) begin
            rd_sel_i = 2'(s);
            #1;
            chk("R1", "reset reg", rd_data_o, (s == 2) ? 8'h0F : 8'h00);
        end
        chk("R1", "reset irq_n", {7'd0, irq_n_o}, 8'h01);
        chk("R1", "reset oe", {6'd0, vec_oe_o, ack_done_o}, 8'h00);

        // R4: select 0 write changes nothing
        wr(2'd0, 8'hFF);
        rd_sel_i = 2'd1; #1; chk("R4", "sel0 write mask", rd_data_o, 8'h00);
        rd_sel_i = 2'd2; #1; chk("R4", "sel0 write vec",  rd_data_o, 8'h0F);

        // R7: acknowledge with nothing pending
        wr(2'd1, 8'h81);
        wr(2'd2, 8'hA5);
        cond_i = 8'h00; cycle();
        ack_n_i = 1'b0; cycle(); cycle();
        ack_n_i = 1'b1; cycle();

        // R5/R6: granted acknowledge held several cycles
        cond_i = 8'h80; cycle();
        ack_n_i = 1'b0; cycle(); cycle(); cycle();
        ack_n_i = 1'b1; cycle(); cycle();

        // R9: chain on, chain input low blocks acknowledge
        wr(2'd3, 8'h01);
        chain_in_i = 1'b0; cycle();
        ack_n_i = 1'b0; cycle(); cycle();
        ack_n_i = 1'b1; chain_in_i = 1'b1; cycle();
        // R10: chain input high, pending -> chain output low
        cycle();
        wr(2'd3, 8'h00);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            cond_i     = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            chain_in_i = ($urandom % 5 != 0);
            rd_sel_i   = 2'($urandom);
            if (ack_n_i) ack_n_i = ($urandom % 6 != 0);
            else         ack_n_i = ($urandom % 3 == 0);
            wr_en_i   = ($urandom % 5 == 0);
            wr_sel_i  = 2'($urandom);
            wr_data_i = 8'($urandom);
            cycle();
        end
        wr_en_i = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule